// File: doc/BRIEF.md
# Auto-Reload Gated Timer/Counter

This block is a 16-bit up-counter for a small microcontroller. It advances from one of two sources: a machine-cycle tick, which is the core clock divided by twelve, or falling edges on an asynchronous external count pin. When the count passes its all-ones value, it does not wrap to zero. Instead it takes the value held in a 16-bit reload pair and raises an overflow flag for the interrupt logic.

Software reaches the block through a byte-wide register port: two count bytes, two reload bytes and one control byte. The count can be held off by a run bit. A gate bit adds a further condition: the count then also needs an external level input to be high. The interrupt controller clears the overflow flag with an acknowledge pulse.

Top module: `reload_timer`

## Requirements
- R1: After reset, every register reads 00h and `ovf_flag` is low.
- R2: When the source-select bit (control bit 6) is 0 and the counter runs, the count advances by exactly N in any window of 12*N clock cycles.
- R3: When control bit 6 is 1, the count advances by one for each falling edge of `count_pin`. The pin passes through a two-flop synchroniser, and a pin held low adds no further increments.
- R4: When the run bit (control bit 4) is 0, the count holds its value.
- R5: When the gate bit (control bit 7) is 1, the count advances only while `gate_pin` is high. A low gate level holds the count.
- R6: An advance from FFFFh loads the count with the reload pair ({byte at 8Dh, byte at 8Bh}). The reload bytes themselves are never changed by the counter.
- R7: The same advance sets the overflow flag. The flag is visible on `ovf_flag` and as control bit 5.
- R8: A pulse on `irq_ack` clears the overflow flag, unless an overflow occurs in the same cycle.
- R9: Software can set or clear the overflow flag by writing control bit 5.
- R10: A write to either count byte wins over an advance in the same cycle. The written value is stored and no increment is applied.
- R11: Register addresses are: control 88h, count low 8Ah, reload low 8Bh, count high 8Ch, reload high 8Dh. Control bits 3:0 are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address for both reads and writes |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| count_pin | input | 1 | External count input, asynchronous |
| gate_pin | input | 1 | External gate level, asynchronous |
| irq_ack | input | 1 | Overflow acknowledge from interrupt logic |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The bench goes after five corner cases:
- **Rollover from FFFFh.** A counter that wrapped to zero, or that wrote into the reload bytes, would show the wrong next count or changed reload readback.
- **A count pin held low.** An edge detector that fell back to level sensing would keep counting.
- **A count write in the same cycle as an advance.** A design that gave the advance priority would leave the written value plus one.
- **The gate level.** Ignoring it would let the count move while the gate input is low.
- **The prescaler ratio.** Any ratio other than twelve would be caught by an exact count over a long window.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // register map (decoded by the bus side)
  localparam byte_t ADR_CTL    = 8'h88;
  localparam byte_t ADR_CNT_LO = 8'h8A;
  localparam byte_t ADR_RLD_LO = 8'h8B;
  localparam byte_t ADR_CNT_HI = 8'h8C;
  localparam byte_t ADR_RLD_HI = 8'h8D;

  // control bit positions
  localparam int CTL_GATE = 7;
  localparam int CTL_SRC  = 6;
  localparam int CTL_FLAG = 5;
  localparam int CTL_RUN  = 4;

  function automatic logic at_top(cnt_t c);
    return &c;
  endfunction

  function automatic cnt_t advance(cnt_t c, cnt_t rld);
    return at_top(c) ? rld : c + cnt_t'(1);
  endfunction
endpackage

// File: rtl/reload_timer_prescale.sv
module reload_timer_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] phase;

  assign tick = (phase == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + W'(1);
  end
endmodule

// File: rtl/reload_timer_sync.sv
module reload_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  // sh[0..STAGES-1] synchronise, sh[STAGES] holds the previous sample
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh[0] <= 1'b1;
    else        sh[0] <= pin_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sh[i] <= 1'b1;
      else        sh[i] <= sh[i-1];
    end
  end

  assign level_o = sh[STAGES-1];
  assign fall_o  = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/reload_timer_core.sv
module reload_timer_core
  import reload_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  wr_cnt_lo,
  input  logic  wr_cnt_hi,
  input  logic  wr_rld_lo,
  input  logic  wr_rld_hi,
  input  logic  wr_flag,
  input  logic  flag_wdata,
  input  byte_t wdata,
  input  logic  ack,
  output cnt_t  cnt,
  output cnt_t  rld,
  output logic  flag,
  output logic  wrap
);
  logic cnt_wr;

  assign cnt_wr = wr_cnt_lo | wr_cnt_hi;
  assign wrap   = step & ~cnt_wr & at_top(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      if (wr_cnt_lo) cnt[BYTE_W-1:0]     <= wdata;
      if (wr_cnt_hi) cnt[CNT_W-1:BYTE_W] <= wdata;
    end else if (step) begin
      cnt <= advance(cnt, rld);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld <= '0;
    end else begin
      if (wr_rld_lo) rld[BYTE_W-1:0]     <= wdata;
      if (wr_rld_hi) rld[CNT_W-1:BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (wrap)    flag <= 1'b1;
    else if (wr_flag) flag <= flag_wdata;
    else if (ack)     flag <= 1'b0;
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       count_pin,
  input  logic       gate_pin,
  input  logic       irq_ack,
  output logic       ovf_flag
);
  byte_t ctl;          // bit CTL_FLAG unused here, flag lives in core
  logic  pre_tick;
  logic  cnt_fall, cnt_lvl_unused;
  logic  gate_lvl, gate_fall_unused;
  logic  run, src_ext, step, wrap, flag;
  logic  wr_ctl, wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi;
  logic  cnt_wr, rld_wr;
  cnt_t  cnt, rld;

  assign wr_ctl    = reg_we & (reg_addr == ADR_CTL);
  assign wr_cnt_lo = reg_we & (reg_addr == ADR_CNT_LO);
  assign wr_cnt_hi = reg_we & (reg_addr == ADR_CNT_HI);
  assign wr_rld_lo = reg_we & (reg_addr == ADR_RLD_LO);
  assign wr_rld_hi = reg_we & (reg_addr == ADR_RLD_HI);
  assign cnt_wr    = wr_cnt_lo | wr_cnt_hi;
  assign rld_wr    = wr_rld_lo | wr_rld_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl <= '0;
    else if (wr_ctl) ctl <= reg_wdata;
  end

  reload_timer_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick)
  );

  reload_timer_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(count_pin),
    .level_o(cnt_lvl_unused), .fall_o(cnt_fall)
  );

  reload_timer_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(gate_pin),
    .level_o(gate_lvl), .fall_o(gate_fall_unused)
  );

  assign src_ext = ctl[CTL_SRC];
  assign run     = ctl[CTL_RUN] & (~ctl[CTL_GATE] | gate_lvl);
  assign step    = run & (src_ext ? cnt_fall : pre_tick);

  reload_timer_core u_core (
    .clk(clk), .rst_n(rst_n), .step(step),
    .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
    .wr_rld_lo(wr_rld_lo), .wr_rld_hi(wr_rld_hi),
    .wr_flag(wr_ctl), .flag_wdata(reg_wdata[CTL_FLAG]),
    .wdata(reg_wdata), .ack(irq_ack),
    .cnt(cnt), .rld(rld), .flag(flag), .wrap(wrap)
  );

  assign ovf_flag = flag;

  always_comb begin
    case (reg_addr)
      ADR_CTL: begin
        reg_rdata           = ctl;
        reg_rdata[CTL_FLAG] = flag;
      end
      ADR_CNT_LO: reg_rdata = cnt[BYTE_W-1:0];
      ADR_CNT_HI: reg_rdata = cnt[CNT_W-1:BYTE_W];
      ADR_RLD_LO: reg_rdata = rld[BYTE_W-1:0];
      ADR_RLD_HI: reg_rdata = rld[CNT_W-1:BYTE_W];
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
  import reload_timer_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic step,
  input logic wrap,
  input logic run,
  input logic src_ext,
  input logic pre_tick,
  input logic cnt_wr,
  input logic rld_wr,
  input logic flag_wr,
  input logic irq_ack,
  input logic flag,
  input cnt_t cnt,
  input cnt_t rld
);
  // R6
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == $past(rld));

  // R6
  rld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_wr |=> $stable(rld));

  // R7
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);

  // R4
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !wrap && !flag_wr) |=> !flag);

  // R2
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !src_ext) |-> pre_tick);

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !wrap);
endmodule

bind reload_timer reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .wrap(wrap), .run(run),
  .src_ext(src_ext), .pre_tick(pre_tick), .cnt_wr(cnt_wr),
  .rld_wr(rld_wr), .flag_wr(wr_ctl), .irq_ack(irq_ack),
  .flag(flag), .cnt(cnt), .rld(rld)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       count_pin = 1'b1;
  logic       gate_pin = 1'b0;
  logic       irq_ack = 1'b0;
  logic       ovf_flag;

  int total = 0;
  int bad = 0;

  localparam logic [7:0] A_CTL = 8'h88, A_CL = 8'h8A, A_RL = 8'h8B,
                         A_CH = 8'h8C, A_RH = 8'h8D;

  always #5 clk = ~clk;

  reload_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_pin(count_pin),
    .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] h, l;
    rd(A_CH, h);
    rd(A_CL, l);
    c = {h, l};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(A_CL, v[7:0]);
    wr(A_CH, v[15:8]);
  endtask

  task automatic pulse_pin();
    @(negedge clk); count_pin = 1'b0;
    repeat (3) @(negedge clk);
    count_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_CTL, d); check("R1 ctl", d, 8'h00);
    rd(A_CL, d);  check("R1 cnt_lo", d, 8'h00);
    rd(A_CH, d);  check("R1 cnt_hi", d, 8'h00);
    rd(A_RL, d);  check("R1 rld_lo", d, 8'h00);
    rd(A_RH, d);  check("R1 rld_hi", d, 8'h00);
    check("R1 flag", ovf_flag, 1'b0);
  endtask

  task automatic t_timer();
    logic [15:0] c0, c1;
    set_cnt(16'h0100);
    wr(A_CTL, 8'h10);
    rd_cnt(c0);
    repeat (12 * 5) @(negedge clk);
    rd_cnt(c1);
    check("R2 five ticks", c1 - c0, 5);
    rd_cnt(c0);
    repeat (12 * 3) @(negedge clk);
    rd_cnt(c1);
    check("R2 three ticks", c1 - c0, 3);
    wr(A_CTL, 8'h00);
    rd_cnt(c0);
    repeat (60) @(negedge clk);
    rd_cnt(c1);
    check("R4 stopped", c1, c0);
  endtask

  task automatic t_counter();
    logic [15:0] c;
    wr(A_CTL, 8'h40);
    set_cnt(16'h0000);
    wr(A_CTL, 8'h50);
    pulse_pin(); pulse_pin(); pulse_pin();
    rd_cnt(c);
    check("R3 three edges", c, 16'h0003);
    @(negedge clk); count_pin = 1'b0;
    repeat (40) @(negedge clk);
    rd_cnt(c);
    check("R3 held low", c, 16'h0004);
    count_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd_cnt(c);
    check("R3 rising no count", c, 16'h0004);
    wr(A_CTL, 8'h40);
    pulse_pin();
    rd_cnt(c);
    check("R4 edge while stopped", c, 16'h0004);
  endtask

  task automatic t_rollover();
    logic [15:0] c;
    logic [7:0] d;
    wr(A_CTL, 8'h40);
    wr(A_RL, 8'h34);
    wr(A_RH, 8'h12);
    set_cnt(16'hFFFE);
    wr(A_CTL, 8'h50);
    pulse_pin();
    rd_cnt(c);
    check("R6 at top", c, 16'hFFFF);
    check("R7 flag before wrap", ovf_flag, 1'b0);
    pulse_pin();
    rd_cnt(c);
    check("R6 reloaded", c, 16'h1234);
    check("R7 flag set", ovf_flag, 1'b1);
    rd(A_CTL, d); check("R7 ctl bit5", d, 8'h70);
    rd(A_RL, d);  check("R6 rld_lo kept", d, 8'h34);
    rd(A_RH, d);  check("R6 rld_hi kept", d, 8'h12);
    pulse_pin();
    rd_cnt(c);
    check("R6 counts on after reload", c, 16'h1235);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R8 ack clears", ovf_flag, 1'b0);
  endtask

  task automatic t_flag_write();
    logic [7:0] d;
    wr(A_CTL, 8'h20);
    check("R9 set by write", ovf_flag, 1'b1);
    wr(A_CTL, 8'h00);
    check("R9 clear by write", ovf_flag, 1'b0);
    wr(A_CTL, 8'h0A);
    rd(A_CTL, d); check("R11 low nibble", d, 8'h0A);
    wr(A_CTL, 8'h05);
    rd(A_CTL, d); check("R11 low nibble b", d, 8'h05);
  endtask

  task automatic t_gate();
    logic [15:0] c0, c1;
    gate_pin = 1'b0;
    set_cnt(16'h0040);
    wr(A_CTL, 8'h90);
    rd_cnt(c0);
    repeat (60) @(negedge clk);
    rd_cnt(c1);
    check("R5 gate low holds", c1, c0);
    gate_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd_cnt(c0);
    repeat (12 * 4) @(negedge clk);
    rd_cnt(c1);
    check("R5 gate high counts", c1 - c0, 4);
    gate_pin = 1'b0;
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_priority();
    logic [15:0] c;
    wr(A_CTL, 8'h40);
    set_cnt(16'h0010);
    wr(A_CTL, 8'h50);
    @(negedge clk); count_pin = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_addr = A_CL; reg_wdata = 8'h80; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0; count_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd_cnt(c);
    check("R10 write beats step", c, 16'h0080);
    wr(A_CTL, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_counter();
    t_rollover();
    t_flag_write();
    t_gate();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule